// File: doc/BRIEF.md
# Single-Channel PWM Timer

This block is a 16-bit up-counting timer with one output-compare channel that generates a pulse-width modulated signal on a single pin. Software programs it through a small byte-wide register port. A power-of-two prescaler sets the tick rate. A reload value sets the period in ticks. A compare value sets the duty cycle. A mode field picks one of two PWM shapes, and two bits set the pin polarity and enable the pin.

The compare value can be preloaded so that a new duty cycle only takes effect at the start of the next period, which avoids glitched pulses. A sticky match flag records each time the counter reaches the compare value, and an interrupt request is raised when that flag is set and its enable bit is on. The live counter value is also brought out so that surrounding logic can follow the timer phase.

Top module: `pwm_timer`

## Requirements
- R1: The counter advances once every 2^P clock cycles, where P is the 4-bit prescaler register at address 5 (P = 0 means once per cycle).
- R2: The counter counts 0, 1, ..., A-1 and then returns to 0, where A is the 16-bit reload value (high byte at address 6, low byte at address 7), so one period lasts A ticks; a count at or above A also returns to 0.
- R3: While the reload value is 0 the counter does not change.
- R4: Bit 0 of the control register (address 0) enables counting; while it is 0 the counter holds its value.
- R5: Mode register (address 3) bits [6:4] = 110 selects PWM1: the internal reference is active while count < compare (compare high byte at address 8, low byte at address 9). The pin shows the result for a count value one clock after that count appears on `count_o`.
- R6: Mode bits [6:4] = 111 selects PWM2, with the reference active while count > compare. Codes 000 to 101 force the reference inactive, and so does any direction value in mode bits [1:0] other than 00.
- R7: In the output register (address 4), bit 0 enables the pin and bit 1 selects active-low. Active-high drives the pin to 1 when the reference is active. While the pin is disabled it sits at its inactive level: 0 for active-high and 1 for active-low.
- R8: With mode bit 3 set, a newly written compare value takes effect only when the counter returns to 0. With bit 3 clear, it takes effect at once.
- R9: The match flag (status register at address 2, bit 0) is set when the counter advances from a value equal to the active compare value. Writing the status register with bit 0 = 0 clears it. `irq_o` is 1 exactly when the flag is set and interrupt-enable bit 1 (address 1) is set.
- R10: Every register reads back what was written. Unused bits and reserved mode bit 2 read as 0. After reset all registers, the counter, `pwm_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| count_o | output | 16 | Current counter value |
| pwm_o | output | 1 | PWM pin |
| irq_o | output | 1 | Compare interrupt request |

## Verification
A register write takes effect at the clock edge where the strobe is sampled, and the effect is visible on read-back, counter behaviour and `irq_o` at the next falling edge. The pin is registered, so the bench reads it at the falling edge where `count_o` already shows the following count, and it derives the expected level from the count one below. Duty cycles are measured over a window exactly one period long, taken after two full periods of settling, so the window start does not affect the count. The match flag is read only after the counter has moved past the compare value.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

   localparam logic [3:0] ADR_CTRL  = 4'd0;
   localparam logic [3:0] ADR_IEN   = 4'd1;
   localparam logic [3:0] ADR_STAT  = 4'd2;
   localparam logic [3:0] ADR_MODE  = 4'd3;
   localparam logic [3:0] ADR_OUT   = 4'd4;
   localparam logic [3:0] ADR_PSC   = 4'd5;
   localparam logic [3:0] ADR_RLDH  = 4'd6;
   localparam logic [3:0] ADR_RLDL  = 4'd7;
   localparam logic [3:0] ADR_CMPH  = 4'd8;
   localparam logic [3:0] ADR_CMPL  = 4'd9;

   localparam logic [2:0] SHAPE_BELOW = 3'b110;
   localparam logic [2:0] SHAPE_ABOVE = 3'b111;
   localparam logic [1:0] DIR_OUTPUT  = 2'b00;

   typedef struct packed {
      logic       run;
      logic       match_ien;
      logic       preload;
      logic [1:0] dir;
      logic [2:0] shape;
      logic       low_act;
      logic       pin_en;
   } tmr_cfg_t;

endpackage

// File: rtl/pwm_timer_prescale.sv
module pwm_timer_prescale #(
   parameter int PSC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] psc,
   output logic             tick
);
   localparam int DIV_W = (1 << PSC_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   assign mask = (DIV_W'(1) << psc) - DIV_W'(1);
   assign tick = run && ((div_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_q <= '0;
      else if (run) div_q <= div_q + DIV_W'(1);
      else          div_q <= '0;
   end
endmodule

// File: rtl/pwm_timer_counter.sv
module pwm_timer_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             step,
   output logic             wrap
);
   logic [CNT_W:0] next_ext;

   assign next_ext = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};
   assign step     = tick && (reload != '0);
   assign wrap     = step && (next_ext >= {1'b0, reload});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (wrap) count <= '0;
      else if (step) count <= next_ext[CNT_W-1:0];
   end
endmodule

// File: rtl/pwm_timer_compare.sv
module pwm_timer_compare
   import pwm_timer_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic             step,
   input  logic             wrap,
   input  logic [CNT_W-1:0] cmp_new,
   input  tmr_cfg_t         cfg,
   output logic             match,
   output logic             pwm
);
   logic [CNT_W-1:0] cmp_hold;
   logic [CNT_W-1:0] cmp_act;
   logic             ref_act;
   logic             pin_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cmp_hold <= '0;
      else if (!cfg.preload || wrap) cmp_hold <= cmp_new;
   end

   assign cmp_act = cfg.preload ? cmp_hold : cmp_new;
   assign match   = step && (count == cmp_act);

   always_comb begin
      ref_act = 1'b0;
      if (cfg.dir == DIR_OUTPUT) begin
         case (cfg.shape)
            SHAPE_BELOW: ref_act = (count < cmp_act);
            SHAPE_ABOVE: ref_act = (count > cmp_act);
            default:     ref_act = 1'b0;
         endcase
      end
   end

   assign pin_d = cfg.pin_en ? (ref_act ^ cfg.low_act) : cfg.low_act;

   generate
      if (REG_OUT) begin : g_pin_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwm <= 1'b0;
            else        pwm <= pin_d;
         end
      end else begin : g_pin_comb
         assign pwm = pin_d;
      end
   endgenerate
endmodule

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
   import pwm_timer_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              flag_set,
   output tmr_cfg_t          cfg,
   output logic [PSC_W-1:0]  psc,
   output logic [CNT_W-1:0]  reload,
   output logic [CNT_W-1:0]  cmp,
   output logic              flag
);
   localparam int HI_W = CNT_W - DATA_W;

   logic w_ctrl, w_ien, w_stat, w_mode, w_out, w_psc;
   logic w_rldh, w_rldl, w_cmph, w_cmpl;

   assign w_ctrl = we && (addr == ADDR_W'(ADR_CTRL));
   assign w_ien  = we && (addr == ADDR_W'(ADR_IEN));
   assign w_stat = we && (addr == ADDR_W'(ADR_STAT));
   assign w_mode = we && (addr == ADDR_W'(ADR_MODE));
   assign w_out  = we && (addr == ADDR_W'(ADR_OUT));
   assign w_psc  = we && (addr == ADDR_W'(ADR_PSC));
   assign w_rldh = we && (addr == ADDR_W'(ADR_RLDH));
   assign w_rldl = we && (addr == ADDR_W'(ADR_RLDL));
   assign w_cmph = we && (addr == ADDR_W'(ADR_CMPH));
   assign w_cmpl = we && (addr == ADDR_W'(ADR_CMPL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= '0;
         psc    <= '0;
         reload <= '0;
         cmp    <= '0;
      end else begin
         if (w_ctrl) cfg.run       <= wdata[0];
         if (w_ien)  cfg.match_ien <= wdata[1];
         if (w_mode) begin
            cfg.dir     <= wdata[1:0];
            cfg.preload <= wdata[3];
            cfg.shape   <= wdata[6:4];
         end
         if (w_out) begin
            cfg.pin_en  <= wdata[0];
            cfg.low_act <= wdata[1];
         end
         if (w_psc)  psc                        <= wdata[PSC_W-1:0];
         if (w_rldh) reload[CNT_W-1:DATA_W]     <= wdata[HI_W-1:0];
         if (w_rldl) reload[DATA_W-1:0]         <= wdata;
         if (w_cmph) cmp[CNT_W-1:DATA_W]        <= wdata[HI_W-1:0];
         if (w_cmpl) cmp[DATA_W-1:0]            <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flag <= 1'b0;
      else if (flag_set)          flag <= 1'b1;
      else if (w_stat && !wdata[0]) flag <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(ADR_CTRL): rdata = DATA_W'(cfg.run);
         ADDR_W'(ADR_IEN):  rdata = DATA_W'({cfg.match_ien, 1'b0});
         ADDR_W'(ADR_STAT): rdata = DATA_W'(flag);
         ADDR_W'(ADR_MODE): rdata = DATA_W'({cfg.shape, cfg.preload, 1'b0, cfg.dir});
         ADDR_W'(ADR_OUT):  rdata = DATA_W'({cfg.low_act, cfg.pin_en});
         ADDR_W'(ADR_PSC):  rdata = DATA_W'(psc);
         ADDR_W'(ADR_RLDH): rdata = DATA_W'(reload[CNT_W-1:DATA_W]);
         ADDR_W'(ADR_RLDL): rdata = reload[DATA_W-1:0];
         ADDR_W'(ADR_CMPH): rdata = DATA_W'(cmp[CNT_W-1:DATA_W]);
         ADDR_W'(ADR_CMPL): rdata = cmp[DATA_W-1:0];
         default:           rdata = '0;
      endcase
   end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
   import pwm_timer_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 4,
   parameter int CNT_W   = 16,
   parameter int PSC_W   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [CNT_W-1:0]  count_o,
   output logic              pwm_o,
   output logic              irq_o
);
   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_split
         $error("pwm_timer: CNT_W must be twice DATA_W");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("pwm_timer: ADDR_W must cover the register map");
      end
      if (PSC_W < 1 || PSC_W > 5 || PSC_W > DATA_W) begin : g_bad_psc
         $error("pwm_timer: PSC_W out of range");
      end
   endgenerate

   tmr_cfg_t         cfg;
   logic [PSC_W-1:0] psc;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cmp_new;
   logic             tick, step, wrap, match, flag;
   logic             cnt_run, pin_en, low_act;

   assign cnt_run = cfg.run;
   assign pin_en  = cfg.pin_en;
   assign low_act = cfg.low_act;

   pwm_timer_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .flag_set(match), .cfg(cfg), .psc(psc),
      .reload(reload), .cmp(cmp_new), .flag(flag)
   );

   pwm_timer_prescale #(.PSC_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(cnt_run), .psc(psc), .tick(tick)
   );

   pwm_timer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload),
      .count(count_o), .step(step), .wrap(wrap)
   );

   pwm_timer_compare #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_cmp (
      .clk(clk), .rst_n(rst_n), .count(count_o), .step(step), .wrap(wrap),
      .cmp_new(cmp_new), .cfg(cfg), .match(match), .pwm(pwm_o)
   );

   assign irq_o = flag && cfg.match_ien;
endmodule

// File: rtl/pwm_timer_sva.sv
module pwm_timer_sva #(
   parameter int CNT_W   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] reload,
   input logic             cnt_run,
   input logic             pin_en,
   input logic             low_act,
   input logic             pwm,
   input logic             match,
   input logic             flag
);
   a_r2_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count) |-> (count == $past(count) + CNT_W'(1) || count == '0));

   a_r3_zero_reload_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (reload == '0) |=> $stable(count));

   a_r4_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_run |=> $stable(count));

   a_r9_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> flag);

   generate
      if (REG_OUT) begin : g_idle_reg
         a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_en |=> (pwm == $past(low_act)));
      end else begin : g_idle_comb
         a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_en |-> (pwm == low_act));
      end
   endgenerate
endmodule

bind pwm_timer pwm_timer_sva #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_sva (
   .clk(clk), .rst_n(rst_n), .count(count_o), .reload(reload), .cnt_run(cnt_run),
   .pin_en(pin_en), .low_act(low_act), .pwm(pwm_o), .match(match), .flag(flag)
);

// File: tb/pwm_timer_test.sv
`timescale 1ns/1ps
module pwm_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [15:0] count_o;
   logic        pwm_o, irq_o;

   int total = 0;
   int fails = 0;

   always #10 clk = ~clk;

   pwm_timer uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_o(count_o),
      .pwm_o(pwm_o), .irq_o(irq_o)
   );

   typedef struct packed {
      logic [7:0]  mode;
      logic [7:0]  outc;
      logic [7:0]  psc;
      logic [15:0] rld;
      logic [15:0] cmp;
      logic [15:0] exp_act;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{8'h60, 8'h01, 8'd0, 16'd16, 16'd6,  16'd6},
      '{8'h60, 8'h03, 8'd0, 16'd16, 16'd6,  16'd6},
      '{8'h70, 8'h01, 8'd0, 16'd16, 16'd6,  16'd9},
      '{8'h60, 8'h01, 8'd2, 16'd10, 16'd3,  16'd12},
      '{8'h60, 8'h01, 8'd0, 16'd8,  16'd20, 16'd8},
      '{8'h70, 8'h01, 8'd0, 16'd8,  16'd20, 16'd0},
      '{8'h60, 8'h00, 8'd0, 16'd16, 16'd6,  16'd0},
      '{8'h60, 8'h02, 8'd0, 16'd16, 16'd6,  16'd0},
      '{8'h30, 8'h01, 8'd0, 16'd16, 16'd6,  16'd0},
      '{8'h61, 8'h01, 8'd0, 16'd16, 16'd6,  16'd0},
      '{8'h70, 8'h01, 8'd1, 16'd6,  16'd2,  16'd6},
      '{8'h60, 8'h01, 8'd1, 16'd5,  16'd0,  16'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_cnt(input logic [15:0] v);
      do @(negedge clk); while (count_o != v);
   endtask

   task automatic setup(input vec_t v);
      wr(4'd0, 8'h00);
      wr(4'd5, v.psc);
      wr(4'd6, v.rld[15:8]);
      wr(4'd7, v.rld[7:0]);
      wr(4'd8, v.cmp[15:8]);
      wr(4'd9, v.cmp[7:0]);
      wr(4'd3, v.mode);
      wr(4'd4, v.outc);
      wr(4'd0, 8'h01);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [7:0]  d;
      logic [15:0] c0, c1, mx;
      int          n, bad, per, act;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      for (int a = 0; a < 10; a++) begin
         rd(4'(a), d);
         chk("R10 reset register", d, 0);
      end
      chk("R10 reset count", count_o, 0);
      chk("R10 reset pin", pwm_o, 0);
      chk("R10 reset irq", irq_o, 0);

      // R5 R6 R7: vector table of duty measurements
      for (int i = 0; i < NV; i++) begin
         setup(VECS[i]);
         per = int'(VECS[i].rld) << VECS[i].psc;
         repeat (2 * per + 4) @(negedge clk);
         act = 0;
         for (int k = 0; k < per; k++) begin
            @(negedge clk);
            if (pwm_o == !VECS[i].outc[1]) act++;
         end
         chk($sformatf("R5/R6/R7 vector %0d active cycles", i), act, VECS[i].exp_act);
      end

      // R1: prescaler 2^3
      setup('{8'h60, 8'h01, 8'd3, 16'd100, 16'd6, 16'd0});
      c0 = count_o;
      do @(negedge clk); while (count_o == c0);
      c1 = count_o; n = 0;
      do begin @(negedge clk); n++; end while (count_o == c1);
      chk("R1 ticks per count step", n, 8);

      // R2: reload 5 wraps after 4
      setup('{8'h60, 8'h01, 8'd0, 16'd5, 16'd2, 16'd0});
      repeat (10) @(negedge clk);
      mx = 0; bad = 0; c0 = count_o;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (count_o > mx) mx = count_o;
         if (!(count_o == c0 + 16'd1 || (c0 == 16'd4 && count_o == 16'd0))) bad++;
         c0 = count_o;
      end
      chk("R2 highest count", mx, 4);
      chk("R2 sequence steps", bad, 0);

      // R3: zero reload freezes
      wr(4'd7, 8'h00);
      c0 = count_o;
      repeat (20) @(negedge clk);
      chk("R3 frozen count", count_o, c0);

      // R4: counter disable holds
      wr(4'd7, 8'h05);
      repeat (3) @(negedge clk);
      wr(4'd0, 8'h00);
      c0 = count_o;
      repeat (20) @(negedge clk);
      chk("R4 held count", count_o, c0);
      rd(4'd0, d);
      chk("R4 control readback", d, 0);

      // R8: preload on
      setup('{8'h68, 8'h01, 8'd0, 16'd16, 16'd6, 16'd0});
      wait_cnt(16'd2);
      wr(4'd9, 8'd12);
      wait_cnt(16'd9);
      chk("R8 preload keeps old compare", pwm_o, 0);
      wait_cnt(16'd0);
      wait_cnt(16'd9);
      chk("R8 preload applied after wrap", pwm_o, 1);
      // R8: preload off
      wr(4'd3, 8'h60);
      wr(4'd9, 8'd6);
      wait_cnt(16'd2);
      wr(4'd9, 8'd12);
      wait_cnt(16'd9);
      chk("R8 immediate compare", pwm_o, 1);
      wr(4'd9, 8'd6);

      // R9: match flag and interrupt
      wr(4'd1, 8'h00);
      wait_cnt(16'd10);
      wr(4'd2, 8'h00);
      rd(4'd2, d);
      chk("R9 flag cleared", d, 0);
      chk("R9 irq low after clear", irq_o, 0);
      wait_cnt(16'd8);
      rd(4'd2, d);
      chk("R9 flag set on match", d, 1);
      chk("R9 irq masked", irq_o, 0);
      wr(4'd1, 8'h02);
      chk("R9 irq raised", irq_o, 1);
      wait_cnt(16'd10);
      wr(4'd2, 8'h01);
      chk("R9 write of 1 keeps flag", irq_o, 1);
      wr(4'd2, 8'h00);
      chk("R9 irq dropped by clear", irq_o, 0);

      // R10: readback masking
      wr(4'd3, 8'hFF);
      rd(4'd3, d);
      chk("R10 mode readback", d, 8'h7B);
      wr(4'd4, 8'hFF);
      rd(4'd4, d);
      chk("R10 output readback", d, 8'h03);
      wr(4'd5, 8'hFF);
      rd(4'd5, d);
      chk("R10 prescaler readback", d, 8'h0F);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule